// File: doc/BRIEF.md
# Single-Bus Hardwired Processor Sequencer

This block is a small processor core built around one shared internal bus. A register file of four general registers, the program counter, the instruction register, a memory address latch, a memory data latch, an ALU operand latch, an ALU result latch and the ALU all hang off that bus. A step counter feeds a hardwired decoder that, for every step of every instruction, raises one set of bus-source, bus-destination, ALU and memory control lines. Each step moves at most one operand onto the bus. The ALU result can be routed back onto the bus in the same step.

The memory port has a read request, a write request and a completion input. A step that waits for memory keeps the step counter frozen until completion arrives. The instruction set covers load, store, register/memory exchange, register add, memory subtract and branch-if-zero. Add and subtract update negative and zero flags. Every instruction begins with a three-step fetch, and the program counter is incremented through the ALU during that fetch.

Top module: `bus_cpu_core`

## Requirements
- R1: The reset is asynchronous and active low, and its release passes through a two-stage synchronizer. Reset returns the step counter (`step_o`) to 0, the PC to 0 and both flags to 0. No memory request is raised while reset is active. The first fetch after reset reads address 0.
- R2: The instruction word holds the opcode in bits [15:12], the register field Rn in bits [11:10] and the address field in bits [9:0]. Fetch takes three steps: PC to address latch with a read; PC+1 through the ALU back into PC while waiting for completion; memory data into IR. The next fetch therefore reads the following address.
- R3: A request (`mem_rd`, `mem_wr`) is high only in the first cycle of a step, and `mem_addr` is valid in that cycle. The memory raises `mem_mfc` for one cycle: one cycle after a read is issued, with read data valid, or two cycles after a write is issued. The memory takes write data from `mem_wdata` in that completion cycle. While a waiting step sees no completion, the step number holds, no register loads and no new request is made.
- R4: Opcode 1 (load) puts M[addr] into Rn and takes 6 cycles.
- R5: Opcode 2 (store) writes Rn to M[addr] and takes 7 cycles.
- R6: Opcode 3 (exchange) issues read and write in one step. Memory receives the old Rn, Rn receives the old memory word, and the instruction takes 8 cycles.
- R7: Opcode 4 (add) computes Rn = Rn + R0 with the ALU driving the bus directly and takes 5 cycles.
- R8: Opcode 5 (subtract) computes M[addr] = M[addr] - Rn by complementing the bus operand with carry-in set, and takes 10 cycles.
- R9: Opcode 6 (branch if zero) loads PC from the address field when the Z flag is set and takes 5 cycles. Otherwise it ends after 4 cycles and execution continues in sequence.
- R10: Flag N is bit 15 of the ALU result and flag Z means a result of zero. Both change only in the add and subtract steps that update flags. Loads, stores, exchanges, branches and fetch leave them unchanged.
- R11: Every other opcode is a no-op lasting 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 10 | Memory address, valid while a request is high |
| mem_wdata | output | 16 | Write data (memory data latch) |
| mem_rd | output | 1 | Read request, one cycle |
| mem_wr | output | 1 | Write request, one cycle |
| mem_rdata | input | 16 | Read data, valid with completion |
| mem_mfc | input | 1 | Memory function complete |
| step_o | output | 3 | Current step number |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
The hardest case to reach from the ports is exchange. There a write and a read are outstanding at the same time. The data latch is overwritten from the bus in the first cycle and then again by the read return two cycles later, while the write must still carry the register value. A second hard case is a branch whose outcome rests on a zero flag that only an earlier subtract can set. Each program in the sweep runs load, load, add, store, subtract, exchange, store and branch over many operand pairs and all three non-zero registers. The memory operand of the subtract is chosen so that half the runs produce exactly zero and take the branch, and the other half do not. Instruction lengths are taken from the cycles between fetch starts and checked against the cycle counts in the requirements.

// File: rtl/buscpu_pkg.sv
package buscpu_pkg;

  localparam logic [3:0] OPC_LOAD  = 4'd1;
  localparam logic [3:0] OPC_STORE = 4'd2;
  localparam logic [3:0] OPC_EXCH  = 4'd3;
  localparam logic [3:0] OPC_ADD   = 4'd4;
  localparam logic [3:0] OPC_SUB   = 4'd5;
  localparam logic [3:0] OPC_BZ    = 4'd6;

  // one decoded step worth of control lines
  typedef struct packed {
    logic src_pc;    // PC drives operand source
    logic src_ira;   // IR address field drives operand source
    logic src_mdr;   // data latch drives operand source
    logic src_z;     // result latch drives operand source
    logic src_reg;   // register file drives operand source
    logic rsel_r0;   // register source forced to R0
    logic alu_out;   // ALU result placed on the bus
    logic zero_a;    // ALU A input forced to zero
    logic comp_b;    // ALU B input complemented
    logic cin;       // ALU carry-in
    logic ld_pc;
    logic ld_mar;
    logic ld_mdr;
    logic ld_ir;
    logic ld_y;
    logic ld_z;
    logic ld_reg;    // destination is the IR register field
    logic set_cc;
    logic rd;
    logic wr;
    logic wait_mfc;
    logic fin;       // last step of the instruction
  } ctl_t;

endpackage

// File: rtl/buscpu_alu.sv
module buscpu_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          zero_a,
  input  logic          comp_b,
  input  logic          cin,
  output logic [DW-1:0] sum
);

  logic [DW-1:0] a_eff;
  logic [DW-1:0] b_eff;

  always_comb begin
    a_eff = zero_a ? '0 : opa;
    b_eff = comp_b ? ~opb : opb;
    sum   = a_eff + b_eff + DW'(cin);
  end

endmodule

// File: rtl/buscpu_seq.sv
module buscpu_seq
  import buscpu_pkg::*;
#(
  parameter int STEP_W   = 3,
  parameter bit FAST_ADD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        opcode,
  input  logic              flag_z,
  input  logic              mem_mfc,
  output ctl_t              ctl,
  output logic              ld_ok,
  output logic [STEP_W-1:0] step
);

  localparam logic [STEP_W-1:0] S0 = STEP_W'(0);
  localparam logic [STEP_W-1:0] S1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] S2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] S3 = STEP_W'(3);
  localparam logic [STEP_W-1:0] S4 = STEP_W'(4);
  localparam logic [STEP_W-1:0] S5 = STEP_W'(5);
  localparam logic [STEP_W-1:0] S6 = STEP_W'(6);

  logic [STEP_W-1:0] step_q, step_d;
  logic              first_q, first_d;
  logic              adv;

  // hardwired decoder
  always_comb begin
    ctl = '0;
    unique case (step_q)
      S0: begin ctl.src_pc = 1'b1; ctl.ld_mar = 1'b1; ctl.rd = 1'b1; end
      S1: begin
        ctl.src_pc = 1'b1; ctl.zero_a = 1'b1; ctl.cin = 1'b1;
        ctl.alu_out = 1'b1; ctl.ld_pc = 1'b1; ctl.wait_mfc = 1'b1;
      end
      S2: begin ctl.src_mdr = 1'b1; ctl.ld_ir = 1'b1; end
      default: begin
        unique case (opcode)
          OPC_LOAD: begin
            if (step_q == S3) begin
              ctl.src_ira = 1'b1; ctl.ld_mar = 1'b1; ctl.rd = 1'b1; ctl.wait_mfc = 1'b1;
            end else begin
              ctl.src_mdr = 1'b1; ctl.ld_reg = 1'b1; ctl.fin = 1'b1;
            end
          end
          OPC_STORE: begin
            if (step_q == S3) begin
              ctl.src_ira = 1'b1; ctl.ld_mar = 1'b1;
            end else begin
              ctl.src_reg = 1'b1; ctl.ld_mdr = 1'b1; ctl.wr = 1'b1;
              ctl.wait_mfc = 1'b1; ctl.fin = 1'b1;
            end
          end
          OPC_EXCH: begin
            if (step_q == S3) begin
              ctl.src_ira = 1'b1; ctl.ld_mar = 1'b1;
            end else if (step_q == S4) begin
              ctl.src_reg = 1'b1; ctl.ld_mdr = 1'b1; ctl.rd = 1'b1;
              ctl.wr = 1'b1; ctl.wait_mfc = 1'b1;
            end else begin
              ctl.src_mdr = 1'b1; ctl.ld_reg = 1'b1; ctl.fin = 1'b1;
            end
          end
          OPC_ADD: begin
            if (step_q == S3) begin
              ctl.src_reg = 1'b1; ctl.ld_y = 1'b1;
            end else if (step_q == S4) begin
              ctl.src_reg = 1'b1; ctl.rsel_r0 = 1'b1; ctl.set_cc = 1'b1;
              if (FAST_ADD) begin
                ctl.alu_out = 1'b1; ctl.ld_reg = 1'b1; ctl.fin = 1'b1;
              end else begin
                ctl.ld_z = 1'b1;
              end
            end else begin
              ctl.src_z = 1'b1; ctl.ld_reg = 1'b1; ctl.fin = 1'b1;
            end
          end
          OPC_SUB: begin
            if (step_q == S3) begin
              ctl.src_ira = 1'b1; ctl.ld_mar = 1'b1; ctl.rd = 1'b1; ctl.wait_mfc = 1'b1;
            end else if (step_q == S4) begin
              ctl.src_mdr = 1'b1; ctl.ld_y = 1'b1;
            end else if (step_q == S5) begin
              ctl.src_reg = 1'b1; ctl.comp_b = 1'b1; ctl.cin = 1'b1;
              ctl.ld_z = 1'b1; ctl.set_cc = 1'b1;
            end else begin
              ctl.src_z = 1'b1; ctl.ld_mdr = 1'b1; ctl.wr = 1'b1;
              ctl.wait_mfc = 1'b1; ctl.fin = 1'b1;
            end
          end
          OPC_BZ: begin
            if (step_q == S3) begin
              ctl.fin = ~flag_z;
            end else begin
              ctl.src_ira = 1'b1; ctl.ld_pc = 1'b1; ctl.fin = 1'b1;
            end
          end
          default: ctl.fin = 1'b1;
        endcase
      end
    endcase
  end

  // next-state logic
  always_comb begin
    adv     = ~ctl.wait_mfc | mem_mfc;
    step_d  = step_q;
    first_d = first_q;
    if (rst_n) begin
      first_d = adv;
      if (adv) step_d = ctl.fin ? S0 : step_q + STEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= S0;
      first_q <= 1'b1;
    end else begin
      step_q  <= step_d;
      first_q <= first_d;
    end
  end

  assign ld_ok = first_q & rst_n;
  assign step  = step_q;

  assert_hold_on_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.wait_mfc && !mem_mfc) |=> $stable(step_q));

  assert_end_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.fin && (!ctl.wait_mfc || mem_mfc)) |=> (step_q == S0));

  assert_step_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= S6);

endmodule

// File: rtl/buscpu_dpath.sv
module buscpu_dpath
  import buscpu_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 4,
  parameter int RSW  = 2,
  parameter int AW   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic          ld_ok,
  input  logic          mem_mfc,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [3:0]    opcode,
  output logic          flag_z,
  output logic          flag_n
);

  logic [DW-1:0] pc_q, ir_q, mdr_q, y_q, z_q;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] rf_q [NREG];
  logic          fz_q, fn_q, rd_pend_q;
  logic [DW-1:0] src, bus, sum;
  logic [RSW-1:0] dst_sel, src_sel;

  assign dst_sel = ir_q[AW+RSW-1:AW];
  assign src_sel = ctl.rsel_r0 ? '0 : dst_sel;

  // operand source, then optional ALU result onto the bus
  always_comb begin
    if (ctl.src_pc)       src = pc_q;
    else if (ctl.src_ira) src = DW'(ir_q[AW-1:0]);
    else if (ctl.src_mdr) src = mdr_q;
    else if (ctl.src_z)   src = z_q;
    else if (ctl.src_reg) src = rf_q[src_sel];
    else                  src = '0;
    bus = ctl.alu_out ? sum : src;
  end

  buscpu_alu #(.DW(DW)) u_alu (
    .opa(y_q), .opb(src), .zero_a(ctl.zero_a), .comp_b(ctl.comp_b),
    .cin(ctl.cin), .sum(sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= '0;
      fz_q      <= 1'b0;
      fn_q      <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      if (ctl.ld_pc && ld_ok) pc_q <= bus;
      if (ctl.set_cc && ld_ok) begin
        fz_q <= (sum == '0);
        fn_q <= sum[DW-1];
      end
      if (ctl.rd && ld_ok) rd_pend_q <= 1'b1;
      else if (mem_mfc)    rd_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.ld_ir && ld_ok)  ir_q  <= bus;
    if (ctl.ld_mar && ld_ok) mar_q <= bus[AW-1:0];
    if (ctl.ld_y && ld_ok)   y_q   <= bus;
    if (ctl.ld_z && ld_ok)   z_q   <= sum;
    if (mem_mfc && rd_pend_q)      mdr_q <= mem_rdata;
    else if (ctl.ld_mdr && ld_ok)  mdr_q <= bus;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_rf
    always_ff @(posedge clk) begin
      if (ctl.ld_reg && ld_ok && (dst_sel == RSW'(g))) rf_q[g] <= bus;
    end
  end

  assign mem_addr  = (ctl.ld_mar && ld_ok) ? bus[AW-1:0] : mar_q;
  assign mem_wdata = mdr_q;
  assign opcode    = ir_q[DW-1 -: 4];
  assign flag_z    = fz_q;
  assign flag_n    = fn_q;

  assert_one_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.src_pc, ctl.src_ira, ctl.src_mdr, ctl.src_z, ctl.src_reg}));

  assert_flags_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.set_cc && ld_ok) |=> $stable({fz_q, fn_q}));

  assert_pc_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ok |=> $stable(pc_q));

endmodule

// File: rtl/bus_cpu_core.sv
module bus_cpu_core
  import buscpu_pkg::*;
#(
  parameter int DW       = 16,
  parameter int NREG     = 4,
  parameter bit FAST_ADD = 1'b1,
  localparam int RSW     = $clog2(NREG),
  localparam int AW      = DW - 4 - RSW,
  localparam int STEP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_mfc,
  output logic [STEP_W-1:0] step_o,
  output logic              flag_z,
  output logic              flag_n
);

  logic [1:0] sync_q;
  logic       srst_n;
  ctl_t       ctl;
  logic       ld_ok;
  logic [3:0] opcode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n = sync_q[1];

  buscpu_seq #(.STEP_W(STEP_W), .FAST_ADD(FAST_ADD)) u_seq (
    .clk(clk), .rst_n(srst_n), .opcode(opcode), .flag_z(flag_z),
    .mem_mfc(mem_mfc), .ctl(ctl), .ld_ok(ld_ok), .step(step_o)
  );

  buscpu_dpath #(.DW(DW), .NREG(NREG), .RSW(RSW), .AW(AW)) u_dp (
    .clk(clk), .rst_n(srst_n), .ctl(ctl), .ld_ok(ld_ok), .mem_mfc(mem_mfc),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .opcode(opcode), .flag_z(flag_z), .flag_n(flag_n)
  );

  assign mem_rd = ctl.rd & ld_ok;
  assign mem_wr = ctl.wr & ld_ok;

  assert_single_request_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_rd || mem_wr) |=> !(mem_rd || mem_wr));

endmodule

// File: tb/sim_bus_cpu_core.sv
module sim_bus_cpu_core;

  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_rdata = '0;
  logic        mem_mfc = 1'b0;
  logic [2:0]  step_o;
  logic        flag_z, flag_n;

  int vectors = 0;
  int fails = 0;

  always #(CLK_T/2) clk = ~clk;

  bus_cpu_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata), .mem_mfc(mem_mfc),
    .step_o(step_o), .flag_z(flag_z), .flag_n(flag_n)
  );

  // behavioural memory: read done one cycle after issue, write two
  logic [15:0] mem [1024];
  int          busy;
  logic [9:0]  req_addr;
  logic [15:0] cap;
  logic        wpend;

  always @(negedge clk) begin
    if (!rst_n) begin
      busy = 0; mem_mfc = 1'b0;
    end else begin
      if (busy == 1) begin
        mem_mfc = 1'b1; mem_rdata = cap;
        if (wpend) mem[req_addr] = mem_wdata;
        busy = 0;
      end else begin
        mem_mfc = 1'b0;
        if (busy > 1) busy--;
      end
      if (mem_rd || mem_wr) begin
        busy = mem_wr ? 2 : 1;
        req_addr = mem_addr; cap = mem[mem_addr]; wpend = mem_wr;
      end
    end
  end

  // instruction boundary monitor: a fetch starts at step 0 with a read
  int lens [16];
  int starts, cur, wr_cnt;
  logic [9:0] fetch_addr [2];

  always @(negedge clk) begin
    if (!rst_n) begin
      starts = 0; cur = 0; wr_cnt = 0;
    end else begin
      if (mem_wr) wr_cnt++;
      if (step_o == 3'd0 && mem_rd) begin
        if (starts > 0 && starts <= 16) lens[starts-1] = cur;
        if (starts < 2) fetch_addr[starts] = mem_addr;
        starts++; cur = 1;
      end else if (starts > 0) cur++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input int op, input int r, input int a);
    return {op[3:0], r[1:0], a[9:0]};
  endfunction

  function automatic logic [15:0] val(input int i);
    if (i == 0) return 16'h0000;
    if (i == 1) return 16'hFFFF;
    if (i == 2) return 16'h8000;
    return 16'(i * 16'h1357 + 16'h0101);
  endfunction

  task automatic run_case(input logic [15:0] a, input logic [15:0] b,
                          input logic [15:0] c, input logic [15:0] e, input int k);
    logic [15:0] sab, d, f;
    bit taken;
    int exp_len [11];
    int cyc;
    f = 16'hBEEF;
    rst_n = 1'b0;
    @(negedge clk); #1;
    check("R1 step in reset", int'(step_o), 0);
    check("R1 no request in reset", int'({mem_rd, mem_wr}), 0);
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    mem[0] = ins(1, 0, 100);
    mem[1] = ins(1, k, 101);
    mem[2] = ins(4, k, 0);
    mem[3] = ins(2, k, 102);
    mem[4] = ins(5, k, 103);
    mem[5] = ins(3, k, 104);
    mem[6] = ins(2, k, 105);
    mem[7] = ins(6, 0, 10);
    mem[8] = ins(2, 0, 106);
    mem[9] = ins(15, 0, 0);
    mem[100] = a; mem[101] = b; mem[103] = c; mem[104] = e; mem[106] = f;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (starts < 12 && cyc < 400) begin
      @(negedge clk); #1; cyc++;
    end
    check("R3 run finished (watchdog)", int'(cyc < 400), 1);

    sab = a + b;
    d = c - sab;
    taken = (d == 16'h0000);
    exp_len = '{6, 6, 5, 7, 10, 8, 7, 4, 4, 4, 4};
    if (taken) exp_len[7] = 5; else exp_len[8] = 7;

    check("R1 first fetch address", int'(fetch_addr[0]), 0);
    check("R2 second fetch address", int'(fetch_addr[1]), 1);
    check("R4 load length", lens[0], exp_len[0]);
    check("R4 load length Rn", lens[1], exp_len[1]);
    check("R7 add length", lens[2], exp_len[2]);
    check("R5 store length", lens[3], exp_len[3]);
    check("R8 sub length", lens[4], exp_len[4]);
    check("R6 exchange length", lens[5], exp_len[5]);
    check("R5 store length after exchange", lens[6], exp_len[6]);
    check("R9 branch length", lens[7], exp_len[7]);
    check(taken ? "R11 no-op length" : "R9 fall-through store length", lens[8], exp_len[8]);
    check("R11 no-op length", lens[9], exp_len[9]);
    check("R11 no-op length", lens[10], exp_len[10]);

    check("R7 add result stored", int'(mem[102]), int'(sab));
    check("R8 sub result", int'(mem[103]), int'(d));
    check("R6 exchange memory gets register", int'(mem[104]), int'(sab));
    check("R6 exchange register gets memory", int'(mem[105]), int'(e));
    check("R9 branch skip", int'(mem[106]), taken ? int'(f) : int'(a));
    check("R10 zero flag", int'(flag_z), int'(taken));
    check("R10 negative flag", int'(flag_n), int'(d[15]));
    check("R3 write pulse count", wr_cnt, taken ? 4 : 5);
  endtask

  initial begin
    #(CLK_T * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [15:0] a, b, c;
        a = val(i);
        b = val(j + 3);
        c = (j % 2 == 0) ? 16'(a + b) : 16'(a + b + 16'(j * 3 + i + 1));
        run_case(a, b, c, val(i + j + 5), ((i + j) % 3) + 1);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule